// File: doc/BRIEF.md
# Block address translation matcher

This block maps a 32-bit effective address onto a real address through a small, programmable set of block translation entries. Each entry is a pair of 32-bit words, an upper word and a lower word. There are two banks of entries. Instruction fetches look in the fetch bank, and loads and stores look in the data bank. A lookup returns three things: a hit flag, the real address aligned to a 4 KiB page, and read, write and execute permission bits. Exceptions and page-table walks belong to the logic around the block.

Entries are loaded through a one-word write port. A mode input selects how every entry is decoded. In the standard format, privilege-gated valid bits sit in the upper word, the block length is shifted by 15 and a two-bit protection code sits in the lower word. In the legacy format, a single valid bit and the block length sit in the lower word, the length is shifted by 17, and the upper word holds the protection keys. When several entries match, the entry with the lowest index is used.

Requests use a valid/ready handshake. The result is registered and appears one cycle after the request is accepted. It is held while the consumer stalls.

Top module: `blk_xlate_match`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every entry word is zero, so every lookup misses.
- R2: A lookup with `req_fetch`=1 searches only the fetch bank (written with `wr_side`=0). A lookup with `req_fetch`=0 searches only the data bank (`wr_side`=1). `wr_upper`=1 selects the upper word and `wr_upper`=0 selects the lower word.
- R3: In standard format (`legacy_mode`=0), an entry takes part only if its upper-word bit 1 is set for a supervisor lookup (`req_user`=0), or its upper-word bit 0 is set for a user lookup (`req_user`=1).
- R4: In standard format, the mask is 0xFFFE0000 with bits cleared by (upper AND 0x1FFC) shifted left by 15. An entry hits when the mask is non-zero and (EA AND mask) equals (upper AND 0xFFFE0000).
- R5: In legacy format (`legacy_mode`=1), an entry takes part only if lower-word bit 6 is set. Its mask is 0xFFFE0000 with bits cleared by (lower AND 0x3F) shifted left by 17, and the hit rule of R4 applies.
- R6: On a hit, `rsp_raddr` = ((lower AND mask) OR (EA AND NOT mask)) with bits 11:0 cleared.
- R7: Standard permissions come from lower bits 1:0. A value of 0 gives no access, 1 or 3 gives read and execute, and 2 gives read, write and execute.
- R8: Legacy permissions use PP = upper bits 1:0 and a key. The key is upper bit 3 for a supervisor lookup and upper bit 2 for a user lookup. With key 0: PP 0, 1 or 2 gives read and write, and PP 3 gives read only. With key 1: PP 0 gives nothing, PP 1 or 3 gives read, and PP 2 gives read and write. Execute is always granted.
- R9: When several entries hit, the lowest-index entry supplies the address and the permissions.
- R10: On a miss, `rsp_raddr` and all three permission outputs are zero.
- R11: `req_ready` = NOT `rsp_valid` OR `rsp_ready`. An accepted request gives `rsp_valid`=1 on the next cycle. The response is held unchanged while `rsp_ready` is 0.
- R12: A lookup accepted in the same cycle as an entry write uses the entry contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| legacy_mode | input | 1 | 1 selects the legacy entry format |
| wr_en | input | 1 | Entry word write strobe |
| wr_side | input | 1 | 0 selects the fetch bank, 1 selects the data bank |
| wr_upper | input | 1 | 1 selects the upper word, 0 selects the lower word |
| wr_idx | input | IW | Entry index to write |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Request can be accepted |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a load or store |
| req_user | input | 1 | 1 for a user-mode lookup, 0 for supervisor mode |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | An entry matched |
| rsp_raddr | output | 32 | Page-aligned real address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |

## Verification
An entry write and a lookup on that same entry can be accepted on one clock edge. The bench provokes this by raising `wr_en` and `req_valid` in the same cycle: it rewrites the lower word of a data entry while looking up an address that the entry covers. The result is judged correct when the response carries the old real address and old permissions. A following lookup must then show the new values. A stalled response can also meet a new request at the same edge; the bench holds `rsp_ready` low and checks that `req_ready` drops and that the held response does not change.

// File: rtl/blk_xlate_match.sv
module blk_xlate_match #(
  parameter int N_ENT = 4,
  parameter int PAGE_BITS = 12,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          legacy_mode,
  input  logic          wr_en,
  input  logic          wr_side,
  input  logic          wr_upper,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_fetch,
  input  logic          req_user,
  input  logic [31:0]   req_ea,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic [31:0]   rsp_raddr,
  output logic          rsp_rd,
  output logic          rsp_wr,
  output logic          rsp_ex
);
  localparam logic [31:0] EPI_M = 32'hFFFE_0000;
  localparam logic [31:0] PG_M  = ~((32'd1 << PAGE_BITS) - 32'd1);

  logic [31:0] iu [N_ENT];
  logic [31:0] il [N_ENT];
  logic [31:0] du [N_ENT];
  logic [31:0] dl [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_ENT; k++) begin
        iu[k] <= '0;
        il[k] <= '0;
        du[k] <= '0;
        dl[k] <= '0;
      end
    end else if (wr_en) begin
      case ({wr_side, wr_upper})
        2'b01:   iu[wr_idx] <= wr_data;
        2'b00:   il[wr_idx] <= wr_data;
        2'b11:   du[wr_idx] <= wr_data;
        default: dl[wr_idx] <= wr_data;
      endcase
    end
  end

  logic [N_ENT-1:0] hit_v;
  logic [31:0]      ra   [N_ENT];
  logic [2:0]       perm [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [31:0] u, l, std_mask, leg_mask, mask;
    logic [1:0]  spp, lpp;
    logic        key;
    assign u = req_fetch ? iu[g] : du[g];
    assign l = req_fetch ? il[g] : dl[g];
    assign std_mask = (req_user ? u[0] : u[1]) ? (EPI_M & ~((u & 32'h0000_1FFC) << 15)) : '0;
    assign leg_mask = l[6] ? (EPI_M & ~((l & 32'h0000_003F) << 17)) : '0;
    assign mask = legacy_mode ? leg_mask : std_mask;
    assign hit_v[g] = (mask != '0) && ((req_ea & mask) == (u & EPI_M));
    assign ra[g] = ((l & mask) | (req_ea & ~mask)) & PG_M;
    assign spp = l[1:0];
    assign lpp = u[1:0];
    assign key = req_user ? u[2] : u[3];
    assign perm[g] = legacy_mode
      ? {!(key && lpp == 2'd0), (key ? (lpp == 2'd2) : (lpp != 2'd3)), 1'b1}
      : {spp != 2'd0, spp == 2'd2, spp != 2'd0};
  end

  logic        any_hit;
  logic [31:0] sel_ra;
  logic [2:0]  sel_perm;

  always_comb begin
    any_hit  = 1'b0;
    sel_ra   = '0;
    sel_perm = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (hit_v[k]) begin
        any_hit  = 1'b1;
        sel_ra   = ra[k];
        sel_perm = perm[k];
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_raddr <= '0;
      {rsp_rd, rsp_wr, rsp_ex} <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= any_hit;
        rsp_raddr <= sel_ra;
        {rsp_rd, rsp_wr, rsp_ex} <= sel_perm;
      end
    end
  end

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_raddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex));

  p_page_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_raddr[PAGE_BITS-1:0] == '0));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_raddr)
                                   && $stable({rsp_rd, rsp_wr, rsp_ex})));

  p_wr_has_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> rsp_rd);
endmodule

// File: tb/blk_xlate_match_tb_top.sv
module blk_xlate_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy_mode = 1'b0;
  logic wr_en = 1'b0, wr_side = 1'b0, wr_upper = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic req_valid = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_raddr;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  blk_xlate_match #(.N_ENT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .wr_en(wr_en), .wr_side(wr_side), .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_fetch(req_fetch), .req_user(req_user),
    .req_ea(req_ea), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_raddr(rsp_raddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic side, input logic upper, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_upper = upper; wr_idx = 2'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic fetch, input logic user, input logic [31:0] ea,
                      input logic hit, input logic [31:0] ra, input logic [2:0] rwx);
    @(negedge clk);
    req_valid = 1'b1; req_fetch = fetch; req_user = user; req_ea = ea;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {29'd0, rsp_valid, rsp_hit, 1'b0}, {29'd0, 1'b1, hit, 1'b0});
    chk(req, rsp_raddr, ra);
    chk(req, {29'd0, rsp_rd, rsp_wr, rsp_ex}, {29'd0, rwx});
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    look("R1 R10 empty miss", 1'b0, 1'b0, 32'h1000_0000, 1'b0, 32'h0, 3'b000);
  endtask

  task automatic t_standard;
    put(1, 1, 0, 32'h1000_0002);
    put(1, 0, 0, 32'h8000_0002);
    look("R4 R6 R7 std hit rw", 0, 0, 32'h1001_2345, 1, 32'h8001_2000, 3'b111);
    look("R3 user gated off", 0, 1, 32'h1001_2345, 0, 32'h0, 3'b000);
    put(1, 1, 0, 32'h1000_0003);
    look("R3 user enabled", 0, 1, 32'h1001_2345, 1, 32'h8001_2000, 3'b111);
    look("R2 fetch bank empty", 1, 0, 32'h1001_2345, 0, 32'h0, 3'b000);
    put(0, 1, 0, 32'h1000_0002);
    put(0, 0, 0, 32'h4000_0001);
    look("R2 R7 fetch pp1", 1, 0, 32'h1001_2345, 1, 32'h4001_2000, 3'b101);
    put(1, 1, 1, 32'h2000_0002);
    put(1, 0, 1, 32'h9000_0000);
    look("R7 pp0 no access", 0, 0, 32'h2000_0000, 1, 32'h9000_0000, 3'b000);
  endtask

  task automatic t_length;
    put(1, 1, 2, 32'h3000_000E);
    put(1, 0, 2, 32'hA000_0002);
    look("R4 R6 length mask hit", 0, 0, 32'h3007_5678, 1, 32'hA007_5000, 3'b111);
    look("R4 beyond length miss", 0, 0, 32'h3008_0000, 0, 32'h0, 3'b000);
  endtask

  task automatic t_priority;
    put(1, 1, 3, 32'h1000_0003);
    put(1, 0, 3, 32'hB000_0001);
    look("R9 lowest index wins", 0, 0, 32'h1000_0000, 1, 32'h8000_0000, 3'b111);
    put(1, 1, 0, 32'h0);
    look("R9 next entry used", 0, 0, 32'h1000_0000, 1, 32'hB000_0000, 3'b101);
  endtask

  task automatic t_legacy;
    legacy_mode = 1'b1;
    put(1, 1, 0, 32'h5000_0005);
    put(1, 0, 0, 32'hC000_0041);
    look("R5 R8 legacy sup key0", 0, 0, 32'h5003_4567, 1, 32'hC003_4000, 3'b111);
    look("R8 legacy user key1 pp1", 0, 1, 32'h5003_4567, 1, 32'hC003_4000, 3'b101);
    look("R5 legacy length miss", 0, 0, 32'h5004_0000, 0, 32'h0, 3'b000);
    look("R5 std entry invalid in legacy", 0, 0, 32'h3007_5678, 0, 32'h0, 3'b000);
    put(1, 1, 0, 32'h5000_0004);
    look("R8 legacy key1 pp0 exec only", 0, 1, 32'h5003_4567, 1, 32'hC003_4000, 3'b001);
    legacy_mode = 1'b0;
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_fetch = 0; req_user = 0; req_ea = 32'h3007_5678;
    @(negedge clk);
    req_ea = 32'h2000_0000;
    chk("R11 valid after accept", {31'd0, rsp_valid}, 32'd1);
    chk("R11 ready low while stalled", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R11 held address", rsp_raddr, 32'hA007_5000);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next request taken", rsp_raddr, 32'h9000_0000);
    @(negedge clk);
    chk("R11 drains", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_side = 1; wr_upper = 0; wr_idx = 2'd1; wr_data = 32'h9100_0002;
    req_valid = 1'b1; req_fetch = 0; req_user = 0; req_ea = 32'h2000_0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R12 old address", rsp_raddr, 32'h9000_0000);
    chk("R12 old perms", {29'd0, rsp_rd, rsp_wr, rsp_ex}, 32'd0);
    look("R12 new contents after", 0, 0, 32'h2000_0000, 1, 32'h9100_0000, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standard();
    t_length();
    t_priority();
    t_legacy();
    t_stall();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule